// File: doc/BRIEF.md
# Three-Slot Long-Word Pipelined Datapath

This block is a small in-order core that executes long instruction words. Each word is 64 bits. It carries three independent operations, and the three operations issue together into three 64-bit lanes, so one word moves 192 bits of data. A word passes through four stages in order: fetch, decode with register read, execute and writeback. When the pipeline is full, one word completes on every clock. The three lanes share a 32-entry register file that has six read ports and three write ports.

The hardware does not check dependencies between slots and has no forwarding network. Correct results depend on the instruction schedule. A word reads a result only when that result comes from a word at least two positions earlier. Reads see a writeback in the same cycle because the register file passes its write data straight through to the reads.

The instruction memory is read asynchronously through the fetch address. Each lane has its own asynchronous data-memory read port, used for loads. A debug port reads any register while the core runs. A stop flag in a word ends fetching. Once the pipeline has drained, `done` rises, and a test environment can then inspect the registers.

Top module: `vliw3_core`

## Requirements
- R1: While reset is active and right after it, `done` is 0, `imemAddr` is 0 and every register reads 0 through the debug port.
- R2: Words are fetched from consecutive addresses, one per clock. Bit 63 is the stop flag and bits 62:60 are reserved. Slot n occupies bits 20n+19:20n, with fields opcode [19:15], destination [14:10], source A [9:5] and source B or shift amount [4:0].
- R3: The results of all three slots of the word fetched while `imemAddr` = k become visible on the debug port after the fourth rising edge that follows that cycle. Debug reads are not bypassed.
- R4: Opcode 1 adds A+B, opcode 2 subtracts A-B and opcode 3 returns the low 64 bits of A*B. All three wrap modulo 2^64.
- R5: Opcode 5 moves A. Opcode 6 writes the zero-extended 10-bit immediate {srcA field, srcB field}. Opcode 8 is A XOR B, opcode 9 is NAND, opcode 10 is NOR and opcode 11 is NOT A.
- R6: Opcode 12 shifts A left logically and opcode 13 shifts it right logically. Opcode 14 rotates A left and opcode 15 rotates it right. The amount for all four is the 5-bit srcB field (0..31), and an amount of 0 leaves A unchanged.
- R7: Opcode 7 writes 1 when A < B as signed 64-bit values, and 0 otherwise.
- R8: Opcode 4 loads. During execute, lane n drives source-A value on `dmemAddr[64n+63:64n]` and writes back the value returned on the same bits of `dmemData`.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: When several slots of one word write the same register, the highest-numbered slot's value remains.
- R11: A word reads the results of words two or more positions earlier. It does not read the result of the word immediately before it, and it gets that register's older value instead.
- R12: In a word whose stop flag is set, all three slots still execute. After that word, fetch stops, `imemAddr` holds and later words never execute. `done` rises after the edge that writes the stop word's results and then stays high.
- R13: Opcode 0 and opcodes 16..31 write nothing. The reserved bits change nothing: they neither stop fetch nor alter any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 8 | Fetch word address |
| imemData | input | 64 | Word at `imemAddr`, read asynchronously |
| dmemAddr | output | 192 | Load addresses, one 64-bit field per lane |
| dmemData | input | 192 | Load data, one 64-bit field per lane |
| dbgAddr | input | 5 | Debug register select |
| dbgData | output | 64 | Debug register value, with register 0 reading as zero |
| done | output | 1 | Fetch has stopped and the pipeline is empty |

## Verification
The hardest case to reach from the ports is the one-word visibility gap. A word immediately behind a producer must read the stale value, while the word after it must read the new value through the register-file bypass. This only shows up when consumers are placed exactly one and two words after their producer. The program does this deliberately. A behavioural model in the bench commits each word's writes at the cycle the requirements give, and the debug port is swept across registers on every clock. A timing slip therefore shows up both as a wrong final value and as a mismatch in the cycle it occurs.

// File: rtl/vliw3_pkg.sv
package vliw3_pkg;
  localparam int LANES    = 3;
  localparam int XLEN     = 64;
  localparam int RAW      = 5;
  localparam int OPW      = 5;
  localparam int NREG     = 1 << RAW;
  localparam int SLOT_W   = OPW + 3 * RAW;
  localparam int HDR_W    = 4;
  localparam int IW       = HDR_W + LANES * SLOT_W;
  localparam int RD_PORTS = 2 * LANES;
  localparam int SHW      = $clog2(XLEN) + 1;
  localparam int IMM_W    = 2 * RAW;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_SUB  = 5'd2,  OP_MUL  = 5'd3,
    OP_LOAD = 5'd4,  OP_MOVE = 5'd5,  OP_IMM  = 5'd6,  OP_SLT  = 5'd7,
    OP_XOR  = 5'd8,  OP_NAND = 5'd9,  OP_NOR  = 5'd10, OP_NOT  = 5'd11,
    OP_SHL  = 5'd12, OP_SHR  = 5'd13, OP_ROL  = 5'd14, OP_ROR  = 5'd15
  } opcode_e;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [RAW-1:0] dst;
    logic [RAW-1:0] srcA;
    logic [RAW-1:0] srcB;
  } slot_t;

  typedef struct packed {
    logic fetchLd;
    logic decLd;
    logic exLd;
    logic wbEn;
  } strobe_t;
endpackage

// File: rtl/vliw3_ctrl.sv
module vliw3_ctrl
  import vliw3_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [HDR_W-1:0] hdr,
  output logic [PC_W-1:0]  pc,
  output strobe_t          stb,
  output logic             done
);
  logic halted, vDec, vEx, vWb, running, stopIn;

  assign running = !halted;
  assign stopIn  = hdr[HDR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      halted <= 1'b0;
      vDec   <= 1'b0;
      vEx    <= 1'b0;
      vWb    <= 1'b0;
    end else begin
      vDec <= running;
      vEx  <= vDec;
      vWb  <= vEx;
      if (running) begin
        if (stopIn) halted <= 1'b1;
        else        pc     <= pc + PC_W'(1);
      end
    end
  end

  always_comb begin
    stb.fetchLd = running;
    stb.decLd   = vDec;
    stb.exLd    = vEx;
    stb.wbEn    = vWb;
  end

  assign done = halted & ~(vDec | vEx | vWb);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stopIn) |=> pc == $past(pc) + PC_W'(1));
  a_r12_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(pc));
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);
  a_r12_drain: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> !done);
  a_r13_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stopIn && $countones(hdr[HDR_W-2:0]) != 0) |=> !halted);
endmodule

// File: rtl/vliw3_regfile.sv
module vliw3_regfile
  import vliw3_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [RD_PORTS-1:0][RAW-1:0]       rdAddr,
  output logic [RD_PORTS-1:0][XLEN-1:0]      rdData,
  input  logic [LANES-1:0]                   we,
  input  logic [LANES-1:0][RAW-1:0]          wa,
  input  logic [LANES-1:0][XLEN-1:0]         wd,
  input  logic [RAW-1:0]                     dbgAddr,
  output logic [XLEN-1:0]                    dbgData
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int s = 0; s < LANES; s++)
        if (we[s] && wa[s] != '0) mem[wa[s]] <= wd[s];
    end
  end

  always_comb begin
    for (int p = 0; p < RD_PORTS; p++) begin
      rdData[p] = (rdAddr[p] == '0) ? '0 : mem[rdAddr[p]];
      for (int s = 0; s < LANES; s++)
        if (we[s] && rdAddr[p] != '0 && wa[s] == rdAddr[p]) rdData[p] = wd[s];
    end
  end

  assign dbgData = (dbgAddr == '0) ? '0 : mem[dbgAddr];

  a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    mem[0] == '0);
  a_r10_last_slot: assert property (@(posedge clk) disable iff (!rstN)
    (we[LANES-1] && wa[LANES-1] != '0) |=> mem[$past(wa[LANES-1])] == $past(wd[LANES-1]));
endmodule

// File: rtl/vliw3_alu.sv
module vliw3_alu
  import vliw3_pkg::*;
(
  input  logic [OPW-1:0]   op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [XLEN-1:0]  ldData,
  input  logic [RAW-1:0]   sh,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  res,
  output logic             wr
);
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] shl, shr;

  assign amt = SHW'(sh);
  assign shl = a << amt;
  assign shr = a >> amt;

  always_comb begin
    wr  = 1'b1;
    res = '0;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_LOAD: res = ldData;
      OP_MOVE: res = a;
      OP_IMM:  res = XLEN'(imm);
      OP_SLT:  res = XLEN'($signed(a) < $signed(b));
      OP_XOR:  res = a ^ b;
      OP_NAND: res = ~(a & b);
      OP_NOR:  res = ~(a | b);
      OP_NOT:  res = ~a;
      OP_SHL:  res = shl;
      OP_SHR:  res = shr;
      OP_ROL:  res = shl | (a >> (SHW'(XLEN) - amt));
      OP_ROR:  res = shr | (a << (SHW'(XLEN) - amt));
      default: wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/vliw3_datapath.sv
module vliw3_datapath
  import vliw3_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [LANES*SLOT_W-1:0] slotBits,
  output logic [LANES*XLEN-1:0]   dmemAddr,
  input  logic [LANES*XLEN-1:0]   dmemData,
  input  logic [RAW-1:0]          dbgAddr,
  output logic [XLEN-1:0]         dbgData
);
  logic [LANES*SLOT_W-1:0]        fetchWord;
  slot_t [LANES-1:0]              decSlot, exSlot;
  logic [RD_PORTS-1:0][RAW-1:0]   rdAddr;
  logic [RD_PORTS-1:0][XLEN-1:0]  rdData;
  logic [LANES-1:0][XLEN-1:0]     exA, exB, aluRes, wbVal;
  logic [LANES-1:0][RAW-1:0]      wbDst;
  logic [LANES-1:0]               aluWr, wbWr, rfWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchWord <= '0;
      exSlot    <= '0;
      exA       <= '0;
      exB       <= '0;
      wbVal     <= '0;
      wbDst     <= '0;
      wbWr      <= '0;
    end else begin
      if (stb.fetchLd) fetchWord <= slotBits;
      for (int l = 0; l < LANES; l++) begin
        if (stb.decLd) begin
          exSlot[l] <= decSlot[l];
          exA[l]    <= rdData[2*l];
          exB[l]    <= rdData[2*l+1];
        end
        if (stb.exLd) begin
          wbVal[l] <= aluRes[l];
          wbDst[l] <= exSlot[l].dst;
          wbWr[l]  <= aluWr[l];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign decSlot[l]                = fetchWord[l*SLOT_W +: SLOT_W];
    assign rdAddr[2*l]               = decSlot[l].srcA;
    assign rdAddr[2*l+1]             = decSlot[l].srcB;
    assign dmemAddr[l*XLEN +: XLEN]  = exA[l];
    assign rfWe[l]                   = wbWr[l] & stb.wbEn;

    vliw3_alu u_alu (
      .op     (exSlot[l].op),
      .a      (exA[l]),
      .b      (exB[l]),
      .ldData (dmemData[l*XLEN +: XLEN]),
      .sh     (exSlot[l].srcB),
      .imm    ({exSlot[l].srcA, exSlot[l].srcB}),
      .res    (aluRes[l]),
      .wr     (aluWr[l])
    );
  end

  vliw3_regfile u_rf (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .we      (rfWe),
    .wa      (wbDst),
    .wd      (wbVal),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData)
  );
endmodule

// File: rtl/vliw3_core.sv
module vliw3_core
  import vliw3_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  output logic [PC_W-1:0]       imemAddr,
  input  logic [IW-1:0]         imemData,
  output logic [LANES*XLEN-1:0] dmemAddr,
  input  logic [LANES*XLEN-1:0] dmemData,
  input  logic [RAW-1:0]        dbgAddr,
  output logic [XLEN-1:0]       dbgData,
  output logic                  done
);
  strobe_t stb;

  vliw3_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .hdr  (imemData[IW-1 -: HDR_W]),
    .pc   (imemAddr),
    .stb  (stb),
    .done (done)
  );

  vliw3_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .slotBits (imemData[LANES*SLOT_W-1:0]),
    .dmemAddr (dmemAddr),
    .dmemData (dmemData),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData)
  );
endmodule

// File: tb/tb_vliw3_core.sv
module tb_vliw3_core;
  import vliw3_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;
  localparam int DEPTH = 1 << PC_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] imemAddr;
  logic [63:0] imemData;
  logic [191:0] dmemAddr, dmemData;
  logic [4:0] dbgAddr = '0;
  logic [63:0] dbgData;
  logic done;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  logic [63:0] imem [DEPTH];
  logic [63:0] wVal [DEPTH][3];
  logic [4:0]  wDst [DEPTH][3];
  logic        wEn  [DEPTH][3];
  logic [63:0] vis  [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw3_core #(.PC_W(PC_W)) dut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemData(dmemData), .dbgAddr(dbgAddr),
    .dbgData(dbgData), .done(done)
  );

  function automatic logic [63:0] memFn(input logic [63:0] a);
    return {a[31:0] ^ 32'h5a5a_c3c3, ~a[63:32]};
  endfunction

  assign imemData = imem[imemAddr];
  for (genvar l = 0; l < 3; l++) begin : g_mem
    assign dmemData[l*64 +: 64] = memFn(dmemAddr[l*64 +: 64]);
  end

  function automatic logic [19:0] sl(input int op, input int d, input int a, input int b);
    return {5'(op), 5'(d), 5'(a), 5'(b)};
  endfunction
  function automatic logic [19:0] li(input int d, input int v);
    return {5'd6, 5'(d), 10'(v)};
  endfunction
  function automatic logic [63:0] wd(input bit stop, input logic [2:0] rsv,
                                     input logic [19:0] s0, input logic [19:0] s1, input logic [19:0] s2);
    return {stop, rsv, s2, s1, s0};
  endfunction

  task automatic mop(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                     input logic [4:0] sb, input logic [9:0] imm,
                     output logic [63:0] r, output logic w);
    logic [127:0] dbl;
    dbl = {a, a};
    w = 1'b1;
    case (op)
      5'd1:  r = a + b;
      5'd2:  r = a - b;
      5'd3:  r = a * b;
      5'd4:  r = memFn(a);
      5'd5:  r = a;
      5'd6:  r = {54'd0, imm};
      5'd7:  r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      5'd8:  r = a ^ b;
      5'd9:  r = ~(a & b);
      5'd10: r = ~(a | b);
      5'd11: r = ~a;
      5'd12: r = a << sb;
      5'd13: r = a >> sb;
      5'd14: begin dbl = dbl << sb; r = dbl[127:64]; end
      5'd15: begin dbl = dbl >> sb; r = dbl[63:0]; end
      default: begin r = '0; w = 1'b0; end
    endcase
  endtask

  // Model: word k reads a register state holding words up to k-2 (R11).
  task automatic buildModel(input int S);
    logic [63:0] mreg [32];
    logic [19:0] s;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int k = 0; k <= S; k++) begin
      for (int l = 0; l < 3; l++) begin
        s = imem[k][l*20 +: 20];
        mop(s[19:15], mreg[s[9:5]], mreg[s[4:0]], s[4:0], s[9:0], wVal[k][l], wEn[k][l]);
        wDst[k][l] = s[14:10];
      end
      if (k > 0)
        for (int l = 0; l < 3; l++)
          if (wEn[k-1][l] && wDst[k-1][l] != 0) mreg[wDst[k-1][l]] = wVal[k-1][l];
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic peek(input int r, input logic [63:0] exp, input string tag, input string what);
    dbgAddr = 5'(r);
    #1;
    check(tag, dbgData, exp, what);
  endtask

  task automatic runProg(input int S, input bit sweepReset);
    buildModel(S);
    for (int i = 0; i < 32; i++) vis[i] = '0;
    rstN = 1'b0;
    dbgAddr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (sweepReset)
      for (int i = 0; i < 32; i++) begin
        dbgAddr = 5'(i);
        #1;
        check("R1", dbgData, 64'd0, "register during reset");
      end
    check("R1", {63'd0, done}, 64'd0, "done during reset");
    check("R1", 64'(imemAddr), 64'd0, "fetch address during reset");
    @(negedge clk);
    rstN = 1'b1;
    for (int n = 0; n <= S + 6; n++) begin
      dbgAddr = 5'(n * 7);
      #1;
      check(n == 0 ? "R1" : (n <= S ? "R2" : "R12"), 64'(imemAddr),
            64'((n < S) ? n : S), "fetch address");
      check("R12", {63'd0, done}, (n >= S + 4) ? 64'd1 : 64'd0, "done flag");
      check("R3", dbgData, vis[dbgAddr], "debug register per cycle");
      @(posedge clk);
      if (n - 3 >= 0 && n - 3 <= S)
        for (int l = 0; l < 3; l++)
          if (wEn[n-3][l] && wDst[n-3][l] != 0) vis[wDst[n-3][l]] = wVal[n-3][l];
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    // Program 1: main function, hazards, conflicts, stop at word 13
    for (int i = 0; i < DEPTH; i++) imem[i] = '0;
    imem[0]  = wd(0, 3'b000, li(1, 5), li(2, 7), li(3, 1000));
    imem[1]  = wd(0, 3'b000, li(4, 3), li(5, 63), 20'd0);
    imem[2]  = wd(0, 3'b000, sl(1, 7, 1, 2), sl(2, 8, 0, 1), sl(3, 9, 3, 3));
    imem[3]  = wd(0, 3'b000, sl(5, 10, 4, 0), sl(5, 11, 7, 0), sl(1, 12, 7, 1));
    imem[4]  = wd(0, 3'b000, sl(7, 13, 8, 1), sl(7, 14, 1, 8), sl(8, 15, 7, 9));
    imem[5]  = wd(0, 3'b000, sl(9, 16, 9, 3), sl(10, 17, 8, 2), sl(11, 18, 1, 0));
    imem[6]  = wd(0, 3'b000, sl(12, 19, 8, 4), sl(13, 20, 8, 31), sl(14, 21, 9, 31));
    imem[7]  = wd(0, 3'b000, sl(15, 22, 8, 7), sl(4, 23, 9, 0), sl(4, 24, 8, 0));
    imem[8]  = wd(0, 3'b000, li(25, 11), li(25, 22), li(25, 33));
    imem[9]  = wd(0, 3'b000, li(26, 1), li(26, 2), li(0, 99));
    imem[10] = wd(0, 3'b101, sl(16, 27, 1, 2), sl(31, 28, 1, 2), sl(3, 29, 8, 8));
    imem[11] = wd(0, 3'b000, sl(2, 1, 2, 1), sl(14, 30, 8, 0), sl(15, 31, 8, 0));
    imem[12] = wd(0, 3'b000, sl(5, 3, 0, 0), sl(1, 4, 0, 4), 20'd0);
    imem[13] = wd(1, 3'b000, li(5, 77), 20'd0, 20'd0);
    imem[14] = wd(0, 3'b000, li(6, 55), 20'd0, 20'd0);
    runProg(13, 1'b1);

    peek(7,  64'd12, "R4", "add");
    peek(8,  64'hFFFF_FFFF_FFFF_FFFB, "R4", "subtract wraps");
    peek(9,  64'd1000000, "R4", "multiply");
    peek(29, 64'd25, "R4", "multiply of negatives");
    peek(1,  64'd2, "R4", "subtract overwrite");
    peek(10, 64'd3, "R5", "move");
    peek(15, vis[15], "R5", "xor");
    peek(16, vis[16], "R5", "nand");
    peek(17, vis[17], "R5", "nor");
    peek(18, 64'hFFFF_FFFF_FFFF_FFFA, "R5", "not");
    peek(19, 64'hFFFF_FFFF_FFFF_FFB0, "R6", "shift left");
    peek(20, 64'h0000_0001_FFFF_FFFF, "R6", "shift right by 31");
    peek(21, vis[21], "R6", "rotate left by 31");
    peek(22, 64'hF7FF_FFFF_FFFF_FFFF, "R6", "rotate right by 7");
    peek(30, 64'hFFFF_FFFF_FFFF_FFFB, "R6", "rotate left by 0");
    peek(31, 64'hFFFF_FFFF_FFFF_FFFB, "R6", "rotate right by 0");
    peek(13, 64'd1, "R7", "signed less: -5 < 5");
    peek(14, 64'd0, "R7", "signed less: 5 < -5");
    peek(23, memFn(64'd1000000), "R8", "load lane 1");
    peek(24, memFn(64'hFFFF_FFFF_FFFF_FFFB), "R8", "load lane 2");
    peek(0,  64'd0, "R9", "register 0 after write");
    peek(4,  64'd3, "R9", "register 0 reads zero as operand");
    peek(3,  64'd0, "R9", "move from register 0");
    peek(25, 64'd33, "R10", "three-slot conflict");
    peek(26, 64'd2, "R10", "two-slot conflict");
    peek(11, 64'd0, "R11", "word directly behind reads stale");
    peek(12, 64'd5, "R11", "stale operand in add");
    peek(27, 64'd0, "R13", "undefined opcode 16");
    peek(28, 64'd0, "R13", "undefined opcode 31");
    peek(5,  64'd77, "R12", "stop word executes");
    peek(6,  64'd0, "R12", "word after stop never executes");

    // Program 2: stop flag in the very first word
    for (int i = 0; i < DEPTH; i++) imem[i] = '0;
    imem[0] = wd(1, 3'b000, li(1, 9), li(2, 513), sl(5, 3, 0, 0));
    imem[1] = wd(0, 3'b000, li(4, 1), 20'd0, 20'd0);
    runProg(0, 1'b0);
    peek(1, 64'd9, "R12", "first-word stop executes slot 0");
    peek(2, 64'd513, "R5", "immediate high bits");
    peek(4, 64'd0, "R12", "word after first-word stop");

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule